// File: doc/BRIEF.md
# Three-Slot Receive Frame Queue with Overrun Policy

This block buffers complete received frames between a frame receiver and software. Each entry is one wide word that carries an identifier, a length and a payload together. The receiver pushes a frame with a single-cycle write strobe. Software always sees the oldest stored frame on the head output, and pops it with a release strobe.

When a frame arrives and all slots are occupied, a mode input decides the outcome. With the mode input low, the newest stored frame is replaced, so the two oldest survive next to the latest arrival. With the mode input high, the queue is locked: it keeps what it holds and discards the arrival. In both modes the event raises a sticky overrun flag, which software clears by writing a one. The block also reports its fill level, a full flag and a not-empty interrupt.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, `level_o` is 0, and `full_o`, `ovr_o` and `irq_o` are all low.
- R2: Frames written with `wr_i` while the queue is not full are stored in arrival order. `head_o` always shows the oldest stored frame. `level_o` is a 2-bit count from 0 to 3, and a write with no release raises it by one.
- R3: A release pulse removes the head frame and presents the next oldest one, lowering `level_o` by one. A release while the queue is empty has no effect, and `level_o` stays 0.
- R4: `full_o` is high exactly when `level_o` equals 3.
- R5: With `lock_i` low, a write while full and with no release replaces the most recently stored frame. After five writes with no releases, the queue holds frames 1, 2 and 5 in that order.
- R6: With `lock_i` high, a write while full and with no release is discarded. After five writes with no releases, the queue holds frames 1, 2 and 3 in that order.
- R7: In either mode, a write while full and with no release sets `ovr_o`. The flag stays set until a cycle with `ovr_clr_i` high and no new overrun clears it. When a set and a clear fall in the same cycle, the set wins.
- R8: A write and a release in the same cycle while full is not an overrun. The head is popped, the new frame is appended as the newest entry, `level_o` stays 3 and `ovr_o` does not change.
- R9: `irq_o` is high exactly when `level_o` is nonzero.
- R10: A write and a release in the same cycle while partly filled leaves `level_o` unchanged, and appends the new frame behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Overrun policy: 0 replaces the newest entry, 1 discards the arrival |
| wr_i | input | 1 | Frame write strobe from the receiver |
| wr_frame_i | input | FRAME_W | Frame word to store |
| rel_i | input | 1 | Release strobe: pops the head entry |
| ovr_clr_i | input | 1 | Write-one clear of the overrun flag |
| head_o | output | FRAME_W | Oldest stored frame |
| level_o | output | LVL_W (2) | Number of stored frames |
| full_o | output | 1 | All slots occupied |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Not-empty interrupt |

## Verification
A wrong fill count first shows as a wrong `level_o`, `full_o` or `irq_o` in the cycle after the bad update. The head sequence shows it at the latest once the queue has been drained. A slot-index or shift error is hidden until the affected frame reaches the head, which takes at most two releases. An overrun path that takes the wrong mode shows as the wrong third frame during the drain. An overrun path that counts a simultaneous release shows as `ovr_o` rising one cycle after that write.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Counter width able to hold 0..n
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
   // Index width able to address 0..n-1
   function automatic int idx_w(input int n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 3,
   parameter int LVL_W = cnt_w(DEPTH),
   parameter int IDX_W = idx_w(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lock_i,
   input  logic             wr_i,
   input  logic             rel_i,
   output logic [LVL_W-1:0] level_o,
   output logic             full_o,
   output logic             shift_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic             ovr_evt_o
);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

   logic [LVL_W-1:0] level_q, level_d;
   logic             grow;

   always_comb begin
      full_o    = (level_q == LVL_MAX);
      shift_o   = rel_i && (level_q != '0);
      ovr_evt_o = wr_i && full_o && !shift_o;
      wr_en_o   = wr_i && !(ovr_evt_o && lock_i);
      wr_idx_o  = ovr_evt_o ? IDX_LAST : IDX_W'(level_q - LVL_W'(shift_o));
      grow      = wr_i && !ovr_evt_o;
      level_d   = level_q + LVL_W'(grow) - LVL_W'(shift_o);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) level_q <= '0;
      else         level_q <= level_d;
   end

   assign level_o = level_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH   = 3,
   parameter int FRAME_W = 80,
   parameter int IDX_W   = idx_w(DEPTH)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               shift_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [FRAME_W-1:0] wr_frame_i,
   output logic [FRAME_W-1:0] head_o
);
   logic [FRAME_W-1:0] slot_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic [FRAME_W-1:0] moved;
      if (gi < DEPTH - 1) begin : g_mid
         assign moved = shift_i ? slot_q[gi+1] : slot_q[gi];
      end else begin : g_tail
         assign moved = slot_q[gi];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            slot_q[gi] <= '0;
         else if (wr_en_i && (wr_idx_i == IDX_W'(gi)))
            slot_q[gi] <= wr_frame_i;
         else
            slot_q[gi] <= moved;
      end
   end

   assign head_o = slot_q[0];
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH   = 3,
   parameter int FRAME_W = 80,
   parameter int LVL_W   = cnt_w(DEPTH)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               lock_i,
   input  logic               wr_i,
   input  logic [FRAME_W-1:0] wr_frame_i,
   input  logic               rel_i,
   input  logic               ovr_clr_i,
   output logic [FRAME_W-1:0] head_o,
   output logic [LVL_W-1:0]   level_o,
   output logic               full_o,
   output logic               ovr_o,
   output logic               irq_o
);
   localparam int IDX_W = idx_w(DEPTH);

   initial begin
      if (DEPTH < 2)               $fatal(1, "rxq_fifo: DEPTH must be at least 2");
      if (FRAME_W < 1)             $fatal(1, "rxq_fifo: FRAME_W must be positive");
      if (LVL_W < cnt_w(DEPTH))    $fatal(1, "rxq_fifo: LVL_W too narrow for DEPTH");
   end

   logic             shift, wr_en, ovr_evt;
   logic [IDX_W-1:0] wr_idx;

   rxq_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IDX_W(IDX_W)) ctrl_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_i    (lock_i),
      .wr_i      (wr_i),
      .rel_i     (rel_i),
      .level_o   (level_o),
      .full_o    (full_o),
      .shift_o   (shift),
      .wr_en_o   (wr_en),
      .wr_idx_o  (wr_idx),
      .ovr_evt_o (ovr_evt)
   );

   rxq_store #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) store_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (shift),
      .wr_en_i    (wr_en),
      .wr_idx_i   (wr_idx),
      .wr_frame_i (wr_frame_i),
      .head_o     (head_o)
   );

   rxq_ovr ovr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ovr_evt),
      .clr_i  (ovr_clr_i),
      .flag_o (ovr_o)
   );

   assign irq_o = (level_o != '0);
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
   parameter int DEPTH = 3,
   parameter int LVL_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lock_i,
   input logic             wr_i,
   input logic             rel_i,
   input logic             ovr_clr_i,
   input logic [LVL_W-1:0] level_o,
   input logic             full_o,
   input logic             ovr_o,
   input logic             irq_o
);
   localparam logic [LVL_W-1:0] LMAX = LVL_W'(DEPTH);

   // R2: count never exceeds capacity
   a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_o <= LMAX);

   // R2: a lone write into a non-full queue adds one
   a_r2_level_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !rel_i && !full_o) |=> (level_o == $past(level_o) + 1'b1));

   // R3: a lone release on an empty queue leaves it empty
   a_r3_empty_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i && !wr_i && level_o == '0) |=> (level_o == '0));

   // R4: full flag tracks the count
   a_r4_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o == (level_o == LMAX));

   // R6: a locked overrun keeps the queue full
   a_r6_lock_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i && wr_i && !rel_i && full_o) |=> full_o);

   // R7: overrun sets the flag
   a_r7_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !rel_i && full_o) |=> ovr_o);

   // R7: the flag is sticky without a clear
   a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_o && !ovr_clr_i) |=> ovr_o);

   // R8: write plus release while full is no overrun
   a_r8_no_false_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovr_o && wr_i && rel_i && full_o) |=> (!ovr_o && full_o));

   // R9: interrupt tracks non-empty
   a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (level_o != '0));
endmodule

bind rxq_fifo rxq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .lock_i    (lock_i),
   .wr_i      (wr_i),
   .rel_i     (rel_i),
   .ovr_clr_i (ovr_clr_i),
   .level_o   (level_o),
   .full_o    (full_o),
   .ovr_o     (ovr_o),
   .irq_o     (irq_o)
);

// File: tb/rxq_fifo_tb_top.sv
module rxq_fifo_tb_top;
   localparam int FW = 80;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          lock_i = 1'b0;
   logic          wr_i = 1'b0;
   logic [FW-1:0] wr_frame_i = '0;
   logic          rel_i = 1'b0;
   logic          ovr_clr_i = 1'b0;
   logic [FW-1:0] head_o;
   logic [1:0]    level_o;
   logic          full_o, ovr_o, irq_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk_i = ~clk_i;

   rxq_fifo dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lock_i     (lock_i),
      .wr_i       (wr_i),
      .wr_frame_i (wr_frame_i),
      .rel_i      (rel_i),
      .ovr_clr_i  (ovr_clr_i),
      .head_o     (head_o),
      .level_o    (level_o),
      .full_o     (full_o),
      .ovr_o      (ovr_o),
      .irq_o      (irq_o)
   );

   function automatic logic [FW-1:0] mk(input int k);
      return {5{16'(k * 4099 + 17)}};
   endfunction

   task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic w, input logic [FW-1:0] d, input logic r, input logic c);
      wr_i = w; wr_frame_i = d; rel_i = r; ovr_clr_i = c;
      @(posedge clk_i); #1;
      wr_i = 1'b0; rel_i = 1'b0; ovr_clr_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      repeat (2) @(posedge clk_i);
      #1 rst_ni = 1'b1;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk_i) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         finish_run();
      end
   end

   initial begin
      #1;
      do_reset();
      // R1 reset state
      chk("R1 level", FW'(level_o), '0);
      chk("R1 full", FW'(full_o), '0);
      chk("R1 ovr", FW'(ovr_o), '0);
      chk("R1 irq", FW'(irq_o), '0);

      // Sweep both policies over 0..6 arrivals with no releases (R2 R4 R5 R6 R7 R9 R3)
      for (int lk = 0; lk < 2; lk++) begin
         for (int n = 0; n <= 6; n++) begin
            int m;
            do_reset();
            lock_i = lk[0];
            for (int k = 1; k <= n; k++) cyc(1'b1, mk(k), 1'b0, 1'b0);
            m = (n < 3) ? n : 3;
            chk("R2 level", FW'(level_o), FW'(m));
            chk("R4 full", FW'(full_o), FW'(m == 3));
            chk("R7 ovr", FW'(ovr_o), FW'(n > 3));
            chk("R9 irq", FW'(irq_o), FW'(m != 0));
            for (int p = 0; p < m; p++) begin
               int id;
               id = (p == 2 && n > 3 && lk == 0) ? n : p + 1;
               if (n > 3 && lk == 0) chk("R5 head", head_o, mk(id));
               else if (n > 3)       chk("R6 head", head_o, mk(id));
               else                  chk("R2 head", head_o, mk(id));
               cyc(1'b0, '0, 1'b1, 1'b0);
               chk("R3 level", FW'(level_o), FW'(m - p - 1));
            end
            chk("R7 sticky", FW'(ovr_o), FW'(n > 3));
            cyc(1'b0, '0, 1'b1, 1'b0);
            chk("R3 empty release", FW'(level_o), '0);
            chk("R9 irq empty", FW'(irq_o), '0);
            cyc(1'b0, '0, 1'b0, 1'b1);
            chk("R7 clear", FW'(ovr_o), '0);
         end
      end

      // R7 set wins over clear
      do_reset();
      lock_i = 1'b0;
      for (int k = 1; k <= 3; k++) cyc(1'b1, mk(k), 1'b0, 1'b0);
      cyc(1'b1, mk(8), 1'b0, 1'b1);
      chk("R7 set beats clear", FW'(ovr_o), 80'd1);

      // R8 write with release while full, both policies
      for (int lk = 0; lk < 2; lk++) begin
         do_reset();
         lock_i = lk[0];
         for (int k = 1; k <= 3; k++) cyc(1'b1, mk(k), 1'b0, 1'b0);
         cyc(1'b1, mk(9), 1'b1, 1'b0);
         chk("R8 ovr", FW'(ovr_o), '0);
         chk("R8 level", FW'(level_o), 80'd3);
         chk("R8 head2", head_o, mk(2));
         cyc(1'b0, '0, 1'b1, 1'b0);
         chk("R8 head3", head_o, mk(3));
         cyc(1'b0, '0, 1'b1, 1'b0);
         chk("R8 head9", head_o, mk(9));
      end

      // R10 write with release while partly filled
      do_reset();
      lock_i = 1'b0;
      cyc(1'b1, mk(1), 1'b0, 1'b0);
      cyc(1'b1, mk(7), 1'b1, 1'b0);
      chk("R10 level1", FW'(level_o), 80'd1);
      chk("R10 head", head_o, mk(7));
      cyc(1'b1, mk(4), 1'b0, 1'b0);
      cyc(1'b1, mk(5), 1'b1, 1'b0);
      chk("R10 level2", FW'(level_o), 80'd2);
      chk("R10 head4", head_o, mk(4));
      cyc(1'b0, '0, 1'b1, 1'b0);
      chk("R10 head5", head_o, mk(5));

      if (!done) begin
         done = 1'b1;
         finish_run();
      end
   end
endmodule